// File: doc/BRIEF.md
# Write-Combining Line Buffer with Read Line Cache

This block sits between a CPU bus carrying one data word plus one strobe per byte lane and a memory controller that only moves whole lines of four words at a time. CPU writes are taken into a single-line write buffer and acknowledged in the cycle they are presented. Later writes that fall in the same aligned line are folded into that buffer. Each byte lane written sets one bit of a per-line byte mask. The buffered line then goes to memory as one masked burst, so bytes nobody wrote keep their old contents.

A single-line read cache keeps the whole line returned by the last burst read. A CPU read to any word of that line is answered in the cycle it is presented, with no memory access. A write that touches the cached line drops it, so a read never returns old data. The write buffer is drained in three cases: when a write arrives for another line, when a read misses the cache, and when the memory side reports a free slot while the CPU is quiet. A read that targets the line still held in the write buffer drains it first and then fetches the line, so the read returns the merged data.

Top module: `burst_merge_cache`

## Requirements
- R1: After reset, `mem_req` and `cpu_ack` are low and both buffers are empty.
- R2: A write presented while the write buffer is empty, or while it holds the same line, is acknowledged in the cycle it is presented, with no memory request.
- R3: Writes to the same 4-word aligned line are merged, and memory sees them as one write burst.
- R4: In the burst mask, bit 2k enables the lower byte of word k and bit 2k+1 enables its upper byte; only bytes whose lane strobe was high are enabled. Memory bytes left masked off keep their previous contents.
- R5: A write to a line other than the buffered one stalls the CPU (`cpu_ack` low) until the buffered line's burst completes; the write is then accepted.
- R6: A read that misses the read cache while the write buffer holds another line completes the write burst before the read burst begins.
- R7: A read to the line pending in the write buffer drains that buffer, then fetches the line, and returns the merged data.
- R8: A read that hits the cached line is acknowledged in the cycle it is presented, with the stored word and no memory request.
- R9: A write to the cached line invalidates it, and the next read of that line fetches it from memory again.
- R10: With no CPU request, a non-empty write buffer and `slot_free` high, the buffer is flushed. A buffer without `slot_free` stays pending, and with an empty buffer `slot_free` causes no request.
- R11: `mem_line` is the word address with its two lowest bits removed. Word k of a line occupies bits 16k+15 down to 16k of the burst data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cpu_req | input | 1 | CPU access request, held until acknowledged |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | CPU word address |
| cpu_wdata | input | DATA_W | CPU write data |
| cpu_be | input | DATA_W/8 | Byte lane strobes, bit 1 upper byte, bit 0 lower byte |
| cpu_ack | output | 1 | Access completes at the clock edge where this is high |
| cpu_rdata | output | DATA_W | Read data, valid while `cpu_ack` is high on a read |
| slot_free | input | 1 | Memory side has an unused slot |
| mem_req | output | 1 | Burst request, held until `mem_done` |
| mem_we | output | 1 | 1 = write burst, 0 = read burst |
| mem_line | output | ADDR_W-2 | Line address of the burst |
| mem_wdata | output | 4*DATA_W | Write burst data |
| mem_wmask | output | 4*DATA_W/8 | Write burst byte enables |
| mem_done | input | 1 | Burst finished; read data is valid in this cycle |
| mem_rdata | input | 4*DATA_W | Read burst data |

## Verification
The hardest cases to reach are ordering cases where two memory bursts must happen in a fixed sequence behind one stalled CPU access. Examples are a read to the line still waiting in the write buffer, and a read miss while another line waits. To get there, the stimulus table first fills a line with writes that use partial byte strobes. It then reads that line and a foreign line. The memory model logs every burst in order, together with its mask and data, and the bench compares the log and the stall of each access with hand-derived values. The idle-slot drain is reached by parking a write with `slot_free` held low and then raising it.

// File: rtl/bmc_pkg.sv
package bmc_pkg;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_FLUSH = 2'd1,
      ST_FILL  = 2'd2
   } bmc_state_e;
endpackage

// File: rtl/bmc_write_buf.sv
module bmc_write_buf #(
   parameter int LINE_W     = 6,
   parameter int OFS_W      = 2,
   parameter int LINE_WORDS = 4,
   parameter int DATA_W     = 16,
   localparam int BYTES     = DATA_W / 8,
   localparam int MASK_W    = LINE_WORDS * BYTES,
   localparam int BURST_W   = LINE_WORDS * DATA_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [LINE_W-1:0]  wr_line,
   input  logic [OFS_W-1:0]   wr_off,
   input  logic [DATA_W-1:0]  wr_data,
   input  logic [BYTES-1:0]   wr_be,
   input  logic               clr,
   output logic               valid,
   output logic [LINE_W-1:0]  line,
   output logic [BURST_W-1:0] burst_data,
   output logic [MASK_W-1:0]  burst_mask
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid <= 1'b0;
         line  <= '0;
      end else if (clr) begin
         valid <= 1'b0;
      end else if (wr_en) begin
         valid <= 1'b1;
         line  <= wr_line;
      end
   end

   for (genvar w = 0; w < LINE_WORDS; w++) begin : g_word
      localparam int unsigned WI = w;
      logic word_sel;
      assign word_sel = wr_en && (wr_off == OFS_W'(WI));
      for (genvar b = 0; b < BYTES; b++) begin : g_byte
         logic [7:0] byte_q;
         logic       en_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               byte_q <= '0;
               en_q   <= 1'b0;
            end else if (clr) begin
               en_q   <= 1'b0;
            end else if (word_sel && wr_be[b]) begin
               byte_q <= wr_data[b*8 +: 8];
               en_q   <= 1'b1;
            end
         end
         assign burst_data[w*DATA_W + b*8 +: 8] = byte_q;
         assign burst_mask[w*BYTES + b]         = en_q;
      end
   end
endmodule

// File: rtl/bmc_read_buf.sv
module bmc_read_buf #(
   parameter int LINE_W     = 6,
   parameter int OFS_W      = 2,
   parameter int LINE_WORDS = 4,
   parameter int DATA_W     = 16,
   localparam int BURST_W   = LINE_WORDS * DATA_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               fill_en,
   input  logic [LINE_W-1:0]  fill_line,
   input  logic [BURST_W-1:0] fill_data,
   input  logic               inv,
   input  logic [LINE_W-1:0]  look_line,
   input  logic [OFS_W-1:0]   look_off,
   output logic               valid,
   output logic               hit,
   output logic [DATA_W-1:0]  rdata
);
   logic [LINE_W-1:0]  tag_q;
   logic [BURST_W-1:0] data_q;
   logic [DATA_W-1:0]  words [LINE_WORDS];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid  <= 1'b0;
         tag_q  <= '0;
         data_q <= '0;
      end else if (fill_en) begin
         valid  <= 1'b1;
         tag_q  <= fill_line;
         data_q <= fill_data;
      end else if (inv) begin
         valid  <= 1'b0;
      end
   end

   for (genvar w = 0; w < LINE_WORDS; w++) begin : g_slice
      assign words[w] = data_q[w*DATA_W +: DATA_W];
   end

   assign hit   = valid && (tag_q == look_line);
   assign rdata = words[look_off];
endmodule

// File: rtl/bmc_ctrl.sv
module bmc_ctrl
   import bmc_pkg::*;
#(
   parameter int LINE_W = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_req,
   input  logic              cpu_we,
   input  logic [LINE_W-1:0] req_line,
   input  logic              slot_free,
   input  logic              wb_valid,
   input  logic [LINE_W-1:0] wb_line,
   input  logic              rb_hit,
   input  logic              mem_done,
   output logic              cpu_ack,
   output logic              wb_wr,
   output logic              wb_clr,
   output logic              rb_fill,
   output logic              rb_inv,
   output logic              mem_req,
   output logic              mem_we,
   output logic [LINE_W-1:0] mem_line
);
   bmc_state_e        state_q, state_d;
   logic [LINE_W-1:0] fill_line_q;
   logic              wb_hit;

   assign wb_hit = wb_valid && (wb_line == req_line);

   always_comb begin
      state_d  = state_q;
      cpu_ack  = 1'b0;
      wb_wr    = 1'b0;
      wb_clr   = 1'b0;
      rb_fill  = 1'b0;
      rb_inv   = 1'b0;
      mem_req  = 1'b0;
      mem_we   = 1'b0;
      mem_line = wb_line;
      case (state_q)
         ST_IDLE: begin
            if (cpu_req) begin
               if (cpu_we) begin
                  if (!wb_valid || wb_hit) begin
                     cpu_ack = 1'b1;
                     wb_wr   = 1'b1;
                     rb_inv  = rb_hit;
                  end else begin
                     state_d = ST_FLUSH;
                  end
               end else if (wb_hit) begin
                  state_d = ST_FLUSH;
               end else if (rb_hit) begin
                  cpu_ack = 1'b1;
               end else if (wb_valid) begin
                  state_d = ST_FLUSH;
               end else begin
                  state_d = ST_FILL;
               end
            end else if (wb_valid && slot_free) begin
               state_d = ST_FLUSH;
            end
         end
         ST_FLUSH: begin
            mem_req  = 1'b1;
            mem_we   = 1'b1;
            mem_line = wb_line;
            if (mem_done) begin
               wb_clr  = 1'b1;
               state_d = ST_IDLE;
            end
         end
         ST_FILL: begin
            mem_req  = 1'b1;
            mem_line = fill_line_q;
            if (mem_done) begin
               rb_fill = 1'b1;
               state_d = ST_IDLE;
            end
         end
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q     <= ST_IDLE;
         fill_line_q <= '0;
      end else begin
         state_q <= state_d;
         if (state_q == ST_IDLE) fill_line_q <= req_line;
      end
   end
endmodule

// File: rtl/burst_merge_cache.sv
module burst_merge_cache #(
   parameter int ADDR_W     = 8,
   parameter int DATA_W     = 16,
   parameter int LINE_WORDS = 4,
   localparam int OFS_W     = $clog2(LINE_WORDS),
   localparam int LINE_W    = ADDR_W - OFS_W,
   localparam int BYTES     = DATA_W / 8,
   localparam int MASK_W    = LINE_WORDS * BYTES,
   localparam int BURST_W   = LINE_WORDS * DATA_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cpu_req,
   input  logic               cpu_we,
   input  logic [ADDR_W-1:0]  cpu_addr,
   input  logic [DATA_W-1:0]  cpu_wdata,
   input  logic [BYTES-1:0]   cpu_be,
   output logic               cpu_ack,
   output logic [DATA_W-1:0]  cpu_rdata,
   input  logic               slot_free,
   output logic               mem_req,
   output logic               mem_we,
   output logic [LINE_W-1:0]  mem_line,
   output logic [BURST_W-1:0] mem_wdata,
   output logic [MASK_W-1:0]  mem_wmask,
   input  logic               mem_done,
   input  logic [BURST_W-1:0] mem_rdata
);
   if (DATA_W % 8 != 0 || DATA_W < 8) begin : g_bad_data
      $error("DATA_W must be a whole number of bytes");
   end
   if (LINE_WORDS < 2 || (LINE_WORDS & (LINE_WORDS - 1)) != 0) begin : g_bad_line
      $error("LINE_WORDS must be a power of two, at least 2");
   end
   if (ADDR_W <= OFS_W) begin : g_bad_addr
      $error("ADDR_W must exceed the line offset width");
   end

   logic [LINE_W-1:0] req_line;
   logic [OFS_W-1:0]  req_off;
   logic              wb_valid, wb_wr, wb_clr;
   logic [LINE_W-1:0] wb_line;
   logic              rb_valid, rb_hit, rb_fill, rb_inv;

   assign req_line = cpu_addr[ADDR_W-1:OFS_W];
   assign req_off  = cpu_addr[OFS_W-1:0];

   bmc_write_buf #(
      .LINE_W(LINE_W), .OFS_W(OFS_W), .LINE_WORDS(LINE_WORDS), .DATA_W(DATA_W)
   ) wbuf_i (
      .clk(clk), .rst_n(rst_n), .wr_en(wb_wr), .wr_line(req_line),
      .wr_off(req_off), .wr_data(cpu_wdata), .wr_be(cpu_be), .clr(wb_clr),
      .valid(wb_valid), .line(wb_line), .burst_data(mem_wdata),
      .burst_mask(mem_wmask)
   );

   bmc_read_buf #(
      .LINE_W(LINE_W), .OFS_W(OFS_W), .LINE_WORDS(LINE_WORDS), .DATA_W(DATA_W)
   ) rbuf_i (
      .clk(clk), .rst_n(rst_n), .fill_en(rb_fill), .fill_line(mem_line),
      .fill_data(mem_rdata), .inv(rb_inv), .look_line(req_line),
      .look_off(req_off), .valid(rb_valid), .hit(rb_hit), .rdata(cpu_rdata)
   );

   bmc_ctrl #(
      .LINE_W(LINE_W)
   ) ctrl_i (
      .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
      .req_line(req_line), .slot_free(slot_free), .wb_valid(wb_valid),
      .wb_line(wb_line), .rb_hit(rb_hit), .mem_done(mem_done),
      .cpu_ack(cpu_ack), .wb_wr(wb_wr), .wb_clr(wb_clr), .rb_fill(rb_fill),
      .rb_inv(rb_inv), .mem_req(mem_req), .mem_we(mem_we), .mem_line(mem_line)
   );
endmodule

// File: rtl/bmc_checker.sv
module bmc_checker #(
   parameter int LINE_W = 6,
   parameter int MASK_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cpu_req,
   input logic              cpu_we,
   input logic              cpu_ack,
   input logic              slot_free,
   input logic              mem_req,
   input logic              mem_we,
   input logic              mem_done,
   input logic [LINE_W-1:0] mem_line,
   input logic [MASK_W-1:0] mem_wmask,
   input logic              wb_valid,
   input logic              rb_valid,
   input logic              rb_hit
);
   a_r8_ack_without_memory: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_ack |-> !mem_req);

   a_r5_request_held: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_done) |=> (mem_req && $stable(mem_line) && $stable(mem_we)));

   a_r4_mask_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_we) |-> (mem_wmask != '0));

   a_r9_invalidate: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_ack && cpu_we && rb_hit) |=> !rb_valid);

   a_r10_idle_flush: assert property (@(posedge clk) disable iff (!rst_n)
      (!cpu_req && wb_valid && slot_free && !mem_req) |=> (mem_req && mem_we));

   a_r6_fill_after_drain: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_we) |-> !wb_valid);
endmodule

bind burst_merge_cache bmc_checker #(.LINE_W(LINE_W), .MASK_W(MASK_W)) chk_i (
   .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
   .cpu_ack(cpu_ack), .slot_free(slot_free), .mem_req(mem_req),
   .mem_we(mem_we), .mem_done(mem_done), .mem_line(mem_line),
   .mem_wmask(mem_wmask), .wb_valid(wb_valid), .rb_valid(rb_valid),
   .rb_hit(rb_hit)
);

// File: tb/burst_merge_cache_tb_top.sv
module burst_merge_cache_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int LAT        = 3;
   localparam int WDOG       = 100000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cpu_req = 1'b0, cpu_we = 1'b0;
   logic [7:0]  cpu_addr = '0;
   logic [15:0] cpu_wdata = '0;
   logic [1:0]  cpu_be = '0;
   logic        cpu_ack;
   logic [15:0] cpu_rdata;
   logic        slot_free = 1'b0;
   logic        mem_req, mem_we;
   logic [5:0]  mem_line;
   logic [63:0] mem_wdata;
   logic [7:0]  mem_wmask;
   logic        mem_done;
   logic [63:0] mem_rdata;

   int checks = 0, errors = 0;
   bit finished = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   burst_merge_cache dut_i (
      .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
      .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_be(cpu_be),
      .cpu_ack(cpu_ack), .cpu_rdata(cpu_rdata), .slot_free(slot_free),
      .mem_req(mem_req), .mem_we(mem_we), .mem_line(mem_line),
      .mem_wdata(mem_wdata), .mem_wmask(mem_wmask), .mem_done(mem_done),
      .mem_rdata(mem_rdata)
   );

   // memory model: word a starts as 16'h5000 + a
   logic [63:0] mem_q [64];
   int          wr_cnt, rd_cnt, ev_n, lat_cnt;
   logic        ev_kind [16];
   logic [5:0]  first_line;
   logic [7:0]  first_mask;
   logic [63:0] first_data;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int l = 0; l < 64; l++)
            for (int k = 0; k < 4; k++)
               mem_q[l][16*k +: 16] <= 16'h5000 + 16'(l*4 + k);
         mem_done <= 1'b0;
         mem_rdata <= '0;
         wr_cnt <= 0; rd_cnt <= 0; ev_n <= 0; lat_cnt <= 0;
         for (int e = 0; e < 16; e++) ev_kind[e] <= 1'b0;
         first_line <= '0; first_mask <= '0; first_data <= '0;
      end else begin
         mem_done <= 1'b0;
         if (mem_req && !mem_done) begin
            if (lat_cnt == LAT) begin
               lat_cnt  <= 0;
               mem_done <= 1'b1;
               if (ev_n < 16) ev_kind[ev_n] <= mem_we;
               ev_n <= ev_n + 1;
               if (mem_we) begin
                  for (int k = 0; k < 8; k++)
                     if (mem_wmask[k]) mem_q[mem_line][8*k +: 8] <= mem_wdata[8*k +: 8];
                  if (wr_cnt == 0) begin
                     first_line <= mem_line;
                     first_mask <= mem_wmask;
                     first_data <= mem_wdata;
                  end
                  wr_cnt <= wr_cnt + 1;
               end else begin
                  mem_rdata <= mem_q[mem_line];
                  rd_cnt <= rd_cnt + 1;
               end
            end else begin
               lat_cnt <= lat_cnt + 1;
            end
         end
      end
   end

   function automatic logic [63:0] expand(input logic [7:0] m);
      logic [63:0] r;
      for (int k = 0; k < 8; k++) r[8*k +: 8] = {8{m[k]}};
      return r;
   endfunction

   task automatic check(input bit ok, input string tag, input logic [63:0] act,
                        input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // one CPU access; returns read data and whether it was stalled
   task automatic access(input logic we, input logic [7:0] addr,
                         input logic [15:0] data, input logic [1:0] be,
                         output logic [15:0] rd, output logic stalled);
      int waited = 0;
      @(negedge clk);
      cpu_req = 1'b1; cpu_we = we; cpu_addr = addr; cpu_wdata = data; cpu_be = be;
      #1;
      while (!cpu_ack && waited < 200) begin
         @(negedge clk); #1;
         waited++;
      end
      rd = cpu_rdata;
      stalled = (waited != 0);
      if (!cpu_ack) check(1'b0, "access timeout", 0, 1);
      @(posedge clk); #1;
      cpu_req = 1'b0;
   endtask

   typedef struct packed {
      logic        we;
      logic [7:0]  addr;
      logic [15:0] data;
      logic [1:0]  be;
      logic [15:0] exp;
      logic        stall;
      logic [3:0]  ew;
      logic [3:0]  er;
      logic [3:0]  req;
   } vec_t;

   localparam vec_t VECS [15] = '{
      '{1'b1, 8'h10, 16'h1111, 2'b11, 16'h0000, 1'b0, 4'd0, 4'd0, 4'd2},  // R2 empty buffer
      '{1'b1, 8'h11, 16'h2222, 2'b01, 16'h0000, 1'b0, 4'd0, 4'd0, 4'd3},  // R3 merge lower
      '{1'b1, 8'h13, 16'h3333, 2'b10, 16'h0000, 1'b0, 4'd0, 4'd0, 4'd3},  // R3 merge upper
      '{1'b0, 8'h12, 16'h0000, 2'b00, 16'h5012, 1'b1, 4'd1, 4'd1, 4'd7},  // R7 pending line
      '{1'b0, 8'h11, 16'h0000, 2'b00, 16'h5022, 1'b0, 4'd1, 4'd1, 4'd4},  // R4 upper kept
      '{1'b0, 8'h13, 16'h0000, 2'b00, 16'h3313, 1'b0, 4'd1, 4'd1, 4'd4},  // R4 lower kept
      '{1'b1, 8'h12, 16'hABCD, 2'b11, 16'h0000, 1'b0, 4'd1, 4'd1, 4'd9},  // R9 write cached line
      '{1'b0, 8'h10, 16'h0000, 2'b00, 16'h1111, 1'b1, 4'd2, 4'd2, 4'd7},  // R7 refetch
      '{1'b0, 8'h12, 16'h0000, 2'b00, 16'hABCD, 1'b0, 4'd2, 4'd2, 4'd9},  // R9 new data
      '{1'b1, 8'h40, 16'h0BEE, 2'b11, 16'h0000, 1'b0, 4'd2, 4'd2, 4'd2},  // R2
      '{1'b1, 8'h24, 16'h7777, 2'b11, 16'h0000, 1'b1, 4'd3, 4'd2, 4'd5},  // R5 other line
      '{1'b0, 8'h41, 16'h0000, 2'b00, 16'h5041, 1'b1, 4'd4, 4'd3, 4'd6},  // R6 miss + drain
      '{1'b0, 8'h40, 16'h0000, 2'b00, 16'h0BEE, 1'b0, 4'd4, 4'd3, 4'd8},  // R8 hit
      '{1'b0, 8'h25, 16'h0000, 2'b00, 16'h5025, 1'b1, 4'd4, 4'd4, 4'd11}, // R11 word 1
      '{1'b0, 8'h24, 16'h0000, 2'b00, 16'h7777, 1'b0, 4'd4, 4'd4, 4'd8}   // R8 hit
   };

   initial begin
      int cyc = 0;
      while (!finished) begin
         @(posedge clk);
         cyc++;
         if (cyc > WDOG) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=<%0d", cyc, WDOG);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
         end
      end
   end

   initial begin
      logic [15:0] rd;
      logic        st;
      string       tag;
      repeat (3) @(negedge clk);
      check(mem_req == 1'b0, "R1 mem_req in reset", 64'(mem_req), 0);
      check(cpu_ack == 1'b0, "R1 cpu_ack in reset", 64'(cpu_ack), 0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      check(mem_req == 1'b0, "R1 mem_req after reset", 64'(mem_req), 0);

      for (int i = 0; i < 15; i++) begin
         access(VECS[i].we, VECS[i].addr, VECS[i].data, VECS[i].be, rd, st);
         tag = $sformatf("R%0d vec %0d", VECS[i].req, i);
         if (!VECS[i].we)
            check(rd == VECS[i].exp, {tag, " rdata"}, 64'(rd), 64'(VECS[i].exp));
         check(st == VECS[i].stall, {tag, " stall"}, 64'(st), 64'(VECS[i].stall));
         @(negedge clk);
         check(wr_cnt == int'(VECS[i].ew), {tag, " write bursts"}, 64'(wr_cnt), 64'(VECS[i].ew));
         check(rd_cnt == int'(VECS[i].er), {tag, " read bursts"}, 64'(rd_cnt), 64'(VECS[i].er));
      end

      // R3 R4 R11: first burst carries the three merged writes of line 4
      check(first_line == 6'd4, "R11 first burst line", 64'(first_line), 4);
      check(first_mask == 8'h87, "R4 first burst mask", 64'(first_mask), 64'h87);
      check((first_data & expand(first_mask)) == 64'h3300_0000_0022_1111,
            "R11 first burst data", first_data & expand(first_mask), 64'h3300_0000_0022_1111);

      // R6 R7: burst order W R W R W W R R
      begin
         logic [7:0] seq_act, seq_exp;
         seq_exp = 8'b0011_0101; // bit e = kind of event e (1 = write)
         for (int e = 0; e < 8; e++) seq_act[e] = ev_kind[e];
         check(seq_act == seq_exp && ev_n == 8, "R6 burst order", 64'(seq_act), 64'(seq_exp));
      end

      // R10: parked write without a free slot stays, drains once slot_free rises
      access(1'b1, 8'h30, 16'h4444, 2'b11, rd, st);
      repeat (5) @(negedge clk);
      check(wr_cnt == 4, "R10 no drain without slot", 64'(wr_cnt), 4);
      slot_free = 1'b1;
      for (int w = 0; w < 30 && wr_cnt != 5; w++) @(negedge clk);
      check(wr_cnt == 5, "R10 drain on free slot", 64'(wr_cnt), 5);
      check(mem_q[12][15:0] == 16'h4444, "R10 drained data", 64'(mem_q[12][15:0]), 64'h4444);
      begin
         logic seen = 1'b0;
         for (int w = 0; w < 10; w++) begin
            @(negedge clk);
            if (mem_req) seen = 1'b1;
         end
         check(!seen, "R10 empty buffer no request", 64'(seen), 0);
      end
      slot_free = 1'b0;

      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule